// File: doc/BRIEF.md
# Frame Transfer Address Sequencer

This block drives the address and count sequence for a single transfer channel that moves words between a buffer in main memory and a peripheral RAM. Software programs a buffer base, a peripheral base, an element count per frame, a frame count and a few mode bits. Each trigger then runs one frame: the block requests one element transfer at a time from a memory-access stub and waits for a one-cycle done pulse before it moves to the next element.

The peripheral address starts again at its base on every frame. The main-memory address keeps advancing across frames, by 4 or 8 bytes per element, or stays fixed in constant mode. When the last frame of the buffer completes, the channel either turns itself off (one-shot) or returns to the buffer base and reloads the frame count (circular). A software disable never cuts a frame short. A trigger that arrives while a frame is running is dropped and recorded in a sticky overrun flag.

Top module: `frame_seq_top`

## Requirements
- R1: After reset, busy_o, mem_req_o, overrun_o and chan_en_o are 0, and elem_left_o and frames_left_o are 0.
- R2: When trig_i is sampled high, the channel is enabled, no frame is active, the frame count left is nonzero and the element count register is nonzero, the block starts a frame. From the next cycle, busy_o and mem_req_o are 1, elem_left_o equals the element count and mem_per_addr_o equals the peripheral base.
- R3: While a frame is active, mem_req_o, mem_main_addr_o, mem_per_addr_o, mem_wr_main_o and elem_left_o hold steady until mem_done_i is sampled high. Each done pulse lowers elem_left_o by one. A done pulse while idle changes nothing.
- R4: Control bit 2 set means constant main addressing: every element uses the same main address. Bit 2 clear means post-increment: the main address rises after each element by 8 bytes when control bit 3 (64-bit size) is set, and by 4 bytes otherwise. The address carries over from one frame to the next.
- R5: mem_per_addr_o starts each frame at the peripheral base and rises by 1 per element within the frame. An element count of 1 therefore gives a constant peripheral address.
- R6: busy_o falls in the cycle after the done pulse for the last element, and frames_left_o drops by one at that point.
- R7: With control bit 1 clear (one-shot), completing the last frame clears chan_en_o and leaves frames_left_o at 0. Later triggers then start nothing.
- R8: With control bit 1 set (circular), completing the last frame returns the main address to the buffer base, reloads frames_left_o, and keeps the channel enabled.
- R9: Clearing the enable bit (control bit 0) during a frame does not stop that frame: all of its elements still complete, with the usual addresses.
- R10: A trigger during an active frame is ignored and sets overrun_o, which stays 1 until reset. A trigger while the channel is disabled is ignored and does not set overrun_o.
- R11: Configuration writes use cfg_addr: 0 = control (bit 0 enable, bit 1 circular, bit 2 constant main, bit 3 64-bit, bit 4 direction, where 1 means the transfer writes main memory), 1 = element count, 2 = frame count, 3 = main base, 4 = peripheral base. Writing the control register with bit 0 set while the channel is disabled loads the main address from the main base and frames_left_o from the frame count. If a frame is running, this load waits until that frame ends.
- R12: mem_wr_main_o shows the direction bit captured at the start of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| trig_i | input | 1 | Frame trigger request |
| mem_req_o | output | 1 | Element transfer request to the memory stub |
| mem_wr_main_o | output | 1 | Direction: 1 writes main memory |
| mem_main_addr_o | output | 32 | Main-memory byte address |
| mem_per_addr_o | output | 16 | Peripheral RAM element address |
| mem_done_i | input | 1 | One-cycle element done acknowledgement |
| busy_o | output | 1 | Transfer in progress |
| overrun_o | output | 1 | Sticky dropped-trigger flag |
| chan_en_o | output | 1 | Channel enable state |
| elem_left_o | output | 16 | Elements remaining in the current frame |
| frames_left_o | output | 16 | Frames remaining in the buffer |

## Verification
Every result is due one clock edge after the input that causes it. A trigger sampled at an edge makes busy_o, mem_req_o and the first addresses visible after that same edge. A done pulse moves to the next addresses or drops busy_o on its edge. A configuration write changes chan_en_o and frames_left_o on the edge that samples it. The bench drives inputs and samples outputs on the falling clock edge, so each check reads the state exactly one rising edge after its stimulus. Wait cycles inserted before a done pulse are checked cycle by cycle for held outputs.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    localparam int REG_IDX_W = 3;

    localparam logic [REG_IDX_W-1:0] REG_CTRL   = 3'd0;
    localparam logic [REG_IDX_W-1:0] REG_ELEMS  = 3'd1;
    localparam logic [REG_IDX_W-1:0] REG_FRAMES = 3'd2;
    localparam logic [REG_IDX_W-1:0] REG_MBASE  = 3'd3;
    localparam logic [REG_IDX_W-1:0] REG_PBASE  = 3'd4;

    localparam int CB_EN     = 0;
    localparam int CB_CIRC   = 1;
    localparam int CB_CONST  = 2;
    localparam int CB_SIZE64 = 3;
    localparam int CB_WRMAIN = 4;
endpackage

// File: rtl/fseq_regs.sv
module fseq_regs
    import fseq_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 32,
    parameter int PAW = 16,
    parameter int CW  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [REG_IDX_W-1:0] cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    input  logic                 hw_dis_i,
    output logic                 en_o,
    output logic                 circ_o,
    output logic                 main_const_o,
    output logic                 size64_o,
    output logic                 wr_main_o,
    output logic [AW-1:0]        main_base_o,
    output logic [PAW-1:0]       per_base_o,
    output logic [CW-1:0]        elem_init_o,
    output logic [CW-1:0]        frame_init_o,
    output logic                 load_o
);
    typedef struct packed {
        logic           en;
        logic           circ;
        logic           main_const;
        logic           size64;
        logic           wr_main;
        logic [AW-1:0]  main_base;
        logic [PAW-1:0] per_base;
        logic [CW-1:0]  elem_init;
        logic [CW-1:0]  frame_init;
    } regs_t;

    regs_t r_d, r_q;
    logic  ctrl_wr;

    always_comb begin
        r_d     = r_q;
        ctrl_wr = cfg_we && (cfg_addr == REG_CTRL);
        load_o  = ctrl_wr && cfg_wdata[CB_EN] && !r_q.en;
        if (cfg_we) begin
            unique case (cfg_addr)
                REG_CTRL: begin
                    r_d.en         = cfg_wdata[CB_EN];
                    r_d.circ       = cfg_wdata[CB_CIRC];
                    r_d.main_const = cfg_wdata[CB_CONST];
                    r_d.size64     = cfg_wdata[CB_SIZE64];
                    r_d.wr_main    = cfg_wdata[CB_WRMAIN];
                end
                REG_ELEMS:  r_d.elem_init  = cfg_wdata[CW-1:0];
                REG_FRAMES: r_d.frame_init = cfg_wdata[CW-1:0];
                REG_MBASE:  r_d.main_base  = cfg_wdata[AW-1:0];
                REG_PBASE:  r_d.per_base   = cfg_wdata[PAW-1:0];
                default: ;
            endcase
        end
        // hardware self-disable at buffer end takes priority
        if (hw_dis_i) r_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o         = r_q.en;
    assign circ_o       = r_q.circ;
    assign main_const_o = r_q.main_const;
    assign size64_o     = r_q.size64;
    assign wr_main_o    = r_q.wr_main;
    assign main_base_o  = r_q.main_base;
    assign per_base_o   = r_q.per_base;
    assign elem_init_o  = r_q.elem_init;
    assign frame_init_o = r_q.frame_init;

    assert_selfdis_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_dis_i |=> !en_o);
endmodule

// File: rtl/fseq_addr_step.sv
module fseq_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic          hold_i,
    input  logic          size64_i,
    output logic [AW-1:0] addr_next_o
);
    localparam logic [AW-1:0] STEP32 = AW'(4);
    localparam logic [AW-1:0] STEP64 = AW'(8);

    logic [AW-1:0] step;

    always_comb begin
        step        = size64_i ? STEP64 : STEP32;
        addr_next_o = hold_i ? addr_i : addr_i + step;
    end
endmodule

// File: rtl/fseq_engine.sv
module fseq_engine #(
    parameter int AW  = 32,
    parameter int PAW = 16,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig_i,
    input  logic           done_i,
    input  logic           en_i,
    input  logic           circ_i,
    input  logic           main_const_i,
    input  logic           size64_i,
    input  logic           wr_main_i,
    input  logic [AW-1:0]  main_base_i,
    input  logic [PAW-1:0] per_base_i,
    input  logic [CW-1:0]  elem_init_i,
    input  logic [CW-1:0]  frame_init_i,
    input  logic           load_i,
    input  logic [AW-1:0]  main_next_i,
    output logic           hw_dis_o,
    output logic           busy_o,
    output logic           dir_o,
    output logic           overrun_o,
    output logic [AW-1:0]  main_addr_o,
    output logic [PAW-1:0] per_addr_o,
    output logic [CW-1:0]  elem_left_o,
    output logic [CW-1:0]  frames_left_o
);
    localparam logic [CW-1:0]  CNT_ONE = CW'(1);
    localparam logic [PAW-1:0] PER_ONE = PAW'(1);

    typedef struct packed {
        logic           busy;
        logic           dir;
        logic           overrun;
        logic           pend;
        logic [CW-1:0]  elem;
        logic [CW-1:0]  frame;
        logic [AW-1:0]  main;
        logic [PAW-1:0] per;
    } eng_t;

    eng_t e_d, e_q;
    logic start_ok;

    always_comb begin
        e_d      = e_q;
        hw_dis_o = 1'b0;
        start_ok = en_i && (e_q.frame != '0) && (elem_init_i != '0);

        if (load_i) begin
            if (e_q.busy) begin
                e_d.pend = 1'b1;
            end else begin
                e_d.main  = main_base_i;
                e_d.frame = frame_init_i;
            end
        end

        if (!e_q.busy) begin
            if (trig_i && start_ok) begin
                e_d.busy = 1'b1;
                e_d.elem = elem_init_i;
                e_d.per  = per_base_i;
                e_d.dir  = wr_main_i;
            end
        end else begin
            if (trig_i) e_d.overrun = 1'b1;
            if (done_i) begin
                e_d.elem = e_q.elem - CNT_ONE;
                e_d.per  = e_q.per + PER_ONE;
                e_d.main = main_next_i;
                if (e_q.elem == CNT_ONE) begin
                    e_d.busy = 1'b0;
                    if (e_q.pend) begin
                        e_d.pend  = 1'b0;
                        e_d.main  = main_base_i;
                        e_d.frame = frame_init_i;
                    end else if (e_q.frame == CNT_ONE) begin
                        if (circ_i) begin
                            e_d.main  = main_base_i;
                            e_d.frame = frame_init_i;
                        end else begin
                            e_d.frame = '0;
                            hw_dis_o  = 1'b1;
                        end
                    end else begin
                        e_d.frame = e_q.frame - CNT_ONE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign busy_o        = e_q.busy;
    assign dir_o         = e_q.dir;
    assign overrun_o     = e_q.overrun;
    assign main_addr_o   = e_q.main;
    assign per_addr_o    = e_q.per;
    assign elem_left_o   = e_q.elem;
    assign frames_left_o = e_q.frame;

    assert_hold_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.busy && !done_i) |=> (e_q.busy && $stable(e_q.main) && $stable(e_q.per)
                                   && $stable(e_q.elem) && $stable(e_q.dir)));

    assert_idle_done_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_q.busy && !trig_i && !load_i) |=> ($stable(e_q.main) && $stable(e_q.elem)
                                               && $stable(e_q.frame)));

    assert_main_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.busy && done_i && (e_q.elem != CNT_ONE) && !main_const_i)
        |=> ((e_q.main - $past(e_q.main)) == ($past(size64_i) ? AW'(8) : AW'(4))));

    assert_frame_start_per_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_q.busy) |-> (e_q.per == $past(per_base_i)));

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.overrun |=> e_q.overrun);

    assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!e_q.busy && !en_i) |=> !e_q.busy);
endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
    import fseq_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 32,
    parameter int PAW = 16,
    parameter int CW  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [REG_IDX_W-1:0] cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    input  logic                 trig_i,
    output logic                 mem_req_o,
    output logic                 mem_wr_main_o,
    output logic [AW-1:0]        mem_main_addr_o,
    output logic [PAW-1:0]       mem_per_addr_o,
    input  logic                 mem_done_i,
    output logic                 busy_o,
    output logic                 overrun_o,
    output logic                 chan_en_o,
    output logic [CW-1:0]        elem_left_o,
    output logic [CW-1:0]        frames_left_o
);
    logic           en, circ, main_const, size64, wr_main, load, hw_dis;
    logic [AW-1:0]  main_base, main_next;
    logic [PAW-1:0] per_base;
    logic [CW-1:0]  elem_init, frame_init;

    fseq_regs #(.DW(DW), .AW(AW), .PAW(PAW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hw_dis_i(hw_dis), .en_o(en), .circ_o(circ),
        .main_const_o(main_const), .size64_o(size64), .wr_main_o(wr_main),
        .main_base_o(main_base), .per_base_o(per_base), .elem_init_o(elem_init),
        .frame_init_o(frame_init), .load_o(load)
    );

    fseq_addr_step #(.AW(AW)) u_step (
        .addr_i(mem_main_addr_o), .hold_i(main_const), .size64_i(size64),
        .addr_next_o(main_next)
    );

    fseq_engine #(.AW(AW), .PAW(PAW), .CW(CW)) u_eng (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .done_i(mem_done_i),
        .en_i(en), .circ_i(circ), .main_const_i(main_const), .size64_i(size64),
        .wr_main_i(wr_main), .main_base_i(main_base), .per_base_i(per_base),
        .elem_init_i(elem_init), .frame_init_i(frame_init), .load_i(load),
        .main_next_i(main_next), .hw_dis_o(hw_dis), .busy_o(busy_o),
        .dir_o(mem_wr_main_o), .overrun_o(overrun_o), .main_addr_o(mem_main_addr_o),
        .per_addr_o(mem_per_addr_o), .elem_left_o(elem_left_o),
        .frames_left_o(frames_left_o)
    );

    assign mem_req_o = busy_o;
    assign chan_en_o = en;
endmodule

// File: tb/tb_frame_seq_top.sv
module tb_frame_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        trig_i = 1'b0;
    logic        mem_done_i = 1'b0;
    logic        mem_req_o, mem_wr_main_o, busy_o, overrun_o, chan_en_o;
    logic [31:0] mem_main_addr_o;
    logic [15:0] mem_per_addr_o, elem_left_o, frames_left_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    frame_seq_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .trig_i(trig_i), .mem_req_o(mem_req_o),
        .mem_wr_main_o(mem_wr_main_o), .mem_main_addr_o(mem_main_addr_o),
        .mem_per_addr_o(mem_per_addr_o), .mem_done_i(mem_done_i), .busy_o(busy_o),
        .overrun_o(overrun_o), .chan_en_o(chan_en_o), .elem_left_o(elem_left_o),
        .frames_left_o(frames_left_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int elems, input int frames, input logic [31:0] mb,
                         input logic [15:0] pb, input logic [31:0] ctrl);
        wr(3'd0, 32'h0);
        wr(3'd1, elems);
        wr(3'd2, frames);
        wr(3'd3, mb);
        wr(3'd4, pb);
        wr(3'd0, ctrl);
    endtask

    task automatic pulse_trig();
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
    endtask

    task automatic start_frame(input int elems, input logic [15:0] pb);
        pulse_trig();
        chk(busy_o == 1'b1 && mem_req_o == 1'b1, "R2 busy/req after trigger", busy_o, 1);
        chk(elem_left_o == 16'(elems), "R2 element count loaded", elem_left_o, elems);
        chk(mem_per_addr_o == pb, "R5 peripheral base at frame start", mem_per_addr_o, pb);
    endtask

    task automatic elem(input logic [31:0] em, input logic [15:0] ep, input int left, input int wt);
        chk(mem_main_addr_o == em, "R4 main address", mem_main_addr_o, em);
        chk(mem_per_addr_o == ep, "R5 peripheral address", mem_per_addr_o, ep);
        chk(elem_left_o == 16'(left), "R3 elements left", elem_left_o, left);
        for (int w = 0; w < wt; w++) begin
            @(negedge clk);
            chk(mem_req_o && mem_main_addr_o == em && mem_per_addr_o == ep
                && elem_left_o == 16'(left), "R3 held while waiting for done",
                mem_main_addr_o, em);
        end
        mem_done_i = 1'b1;
        @(negedge clk);
        mem_done_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy_o && !mem_req_o && !overrun_o && !chan_en_o, "R1 reset flags",
            {busy_o, mem_req_o, overrun_o, chan_en_o}, 0);
        chk(elem_left_o == 0 && frames_left_o == 0, "R1 reset counters",
            {elem_left_o, frames_left_o}, 0);
    endtask

    task automatic t_idle_ignores();
        mem_done_i = 1'b1;
        @(negedge clk);
        mem_done_i = 1'b0;
        chk(elem_left_o == 0 && mem_main_addr_o == 0, "R3 idle done ignored", elem_left_o, 0);
        pulse_trig();
        chk(!busy_o, "R10 trigger while disabled ignored", busy_o, 0);
        chk(!overrun_o, "R10 no overrun when disabled", overrun_o, 0);
    endtask

    task automatic t_oneshot32();
        logic [31:0] m;
        setup(3, 3, 32'h10, 16'h20, 32'h01);
        chk(chan_en_o && frames_left_o == 3, "R11 enable loads frame count", frames_left_o, 3);
        m = 32'h10;
        for (int f = 0; f < 3; f++) begin
            start_frame(3, 16'h20);
            for (int k = 0; k < 3; k++) begin
                elem(m, 16'h20 + 16'(k), 3 - k, (f + k) % 3);
                m += 4;
            end
            chk(!busy_o, "R6 busy drops after last element", busy_o, 0);
            chk(frames_left_o == 16'(2 - f), "R6 frame count decrements", frames_left_o, 2 - f);
        end
        chk(m == 32'h34, "R4 nine words ending at 0x30", m, 32'h34);
        chk(!chan_en_o, "R7 one-shot self disable", chan_en_o, 0);
        pulse_trig();
        chk(!busy_o, "R7 trigger after one-shot end ignored", busy_o, 0);
        chk(!overrun_o, "R10 no overrun after one-shot", overrun_o, 0);
    endtask

    task automatic t_circular64();
        setup(2, 2, 32'h100, 16'h40, 32'h0B);
        start_frame(2, 16'h40);
        elem(32'h100, 16'h40, 2, 0);
        elem(32'h108, 16'h41, 1, 1);
        start_frame(2, 16'h40);
        elem(32'h110, 16'h40, 2, 0);
        elem(32'h118, 16'h41, 1, 0);
        chk(frames_left_o == 2, "R8 circular reloads frame count", frames_left_o, 2);
        chk(chan_en_o, "R8 circular stays enabled", chan_en_o, 1);
        chk(mem_main_addr_o == 32'h100, "R8 circular wraps to base", mem_main_addr_o, 32'h100);
        start_frame(2, 16'h40);
        elem(32'h100, 16'h40, 2, 0);
        elem(32'h108, 16'h41, 1, 0);
        chk(mem_wr_main_o == 1'b0, "R12 direction read", mem_wr_main_o, 0);
    endtask

    task automatic t_constant();
        setup(1, 2, 32'h200, 16'h7, 32'h17);
        for (int f = 0; f < 3; f++) begin
            start_frame(1, 16'h7);
            chk(mem_wr_main_o == 1'b1, "R12 direction write main", mem_wr_main_o, 1);
            elem(32'h200, 16'h7, 1, 1);
        end
        chk(mem_main_addr_o == 32'h200, "R4 constant main address kept", mem_main_addr_o, 32'h200);
    endtask

    task automatic t_disable_overrun();
        setup(4, 5, 32'h300, 16'h10, 32'h01);
        start_frame(4, 16'h10);
        elem(32'h300, 16'h10, 4, 0);
        pulse_trig();
        chk(overrun_o, "R10 overrun on trigger during frame", overrun_o, 1);
        chk(elem_left_o == 3 && busy_o, "R10 frame not restarted", elem_left_o, 3);
        wr(3'd0, 32'h0);
        chk(!chan_en_o && busy_o, "R9 frame continues after disable", busy_o, 1);
        elem(32'h304, 16'h11, 3, 0);
        elem(32'h308, 16'h12, 2, 1);
        elem(32'h30C, 16'h13, 1, 0);
        chk(!busy_o && frames_left_o == 4, "R9 disabled frame completed", frames_left_o, 4);
        pulse_trig();
        chk(!busy_o, "R10 trigger after disable ignored", busy_o, 0);
        chk(overrun_o, "R10 overrun sticky", overrun_o, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignores();
        t_oneshot32();
        t_circular64();
        t_constant();
        t_disable_overrun();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        finish_run();
    end
endmodule